// File: doc/BRIEF.md
# Serial Transmit Port with Status and Interrupt

This block is a host-mapped asynchronous serial transmitter. A host writes a byte into a one-deep holding register through an 8-bit register interface. The byte then moves into a shift register that sends it on the serial line as a framed character. The frame is a low start bit, the data bits least significant first, and a high stop bit. Each bit lasts a fixed number of pulses of a bit-rate enable input. If the host writes the next byte while a character is on the line, the characters leave back to back with no idle gap between them.

The host reads a status byte on the same interface. It holds the holding-register-empty flag, the levels of the carrier and clear-to-send inputs, and a latched interrupt request that also drives the `irq` pin. The request is raised when the shifter finishes a character, nothing is waiting and transmit interrupts are enabled. Any strobed access to the data register drops it. A control write with both low bits set is a soft reset. It aborts the character on the line, empties the holding register, clears the request and disables interrupts.

Top module: `serial_tx_port`

## Requirements
- R1: With `reg_sel`=0 the `rdata` bus carries the status byte: bit 7 interrupt request, bit 3 clear-to-send, bit 2 carrier, bit 1 holding register empty, and bits 6:4 and 0 always 0. With `reg_sel`=1 it carries 0x00, because the receive path is absent. `rdata` follows `reg_sel` combinationally, and a strobe is needed only for side effects.
- R2: Status bit 1 is 0 from the edge that captures a data write until the byte moves into the shifter, and 1 at all other times.
- R3: Status bit 2 equals `carrier_in` and status bit 3 equals `cts_in` in the same cycle.
- R4: The `irq` pin and status bit 7 always carry the same value.
- R5: `txd` is high while idle. A character is one low start bit, then TX_WORD_W data bits LSB first, then one high stop bit, and each bit holds for OVS cycles in which `bit_tick` is 1.
- R6: A data write (`cs`,`wr_en`,`reg_sel`=1) stores `wdata`. If the shifter is idle, the start bit appears on `txd` one cycle after the write edge and the holding register is empty again. A byte written during a character starts on the edge that ends the stop bit, with no idle bit in between.
- R7: On the edge that ends a stop bit with the holding register empty, `irq` becomes 1 if transmit interrupts are enabled. The last control write sets the enable when its `wdata[6:5]` equals 01 and clears it for any other value.
- R8: `irq` stays 0 at the end of a character when interrupts are disabled or when a byte is waiting.
- R9: A strobed read of the data register (`cs`,`rd_en`,`reg_sel`=1) or a data write clears `irq` on its edge.
- R10: A control write whose `wdata[1:0]` is 11 drives `txd` high from the next cycle. It also empties the holding register, clears `irq` and disables transmit interrupts.
- R11: After `rst_n` the status reads 0x02 when both inputs are low, `txd` is high and `irq` is 0.
- R12: While `bit_tick` is 0 the current bit on `txd` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register select: 0 status/control, 1 data |
| cs | input | 1 | Chip select, qualifies strobes |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| carrier_in | input | 1 | Carrier-detect level shown in status |
| cts_in | input | 1 | Clear-to-send level shown in status |
| bit_tick | input | 1 | Bit-rate enable, OVS pulses per bit |
| txd | output | 1 | Serial output line |
| irq | output | 1 | Interrupt request |

## Verification
A wrong bit counter or tick counter shows on `txd` within one bit time, as a sample taken in the middle of a bit that holds the wrong level. It also makes the interrupt arrive earlier or later than 10×OVS cycles after the load. A stale holding-register flag shows in status bit 1 on the cycle after a write, or later as a missing back-to-back character. A bad interrupt latch shows on the `irq` pin on the edge that ends a stop bit or on the edge of a data access. A soft reset that fails to clear state shows as a low `txd`, or as an interrupt after the next character.

// File: rtl/stx_pkg.sv
package stx_pkg;
   localparam int unsigned ST_EMPTY = 1;
   localparam int unsigned ST_DCD   = 2;
   localparam int unsigned ST_CTS   = 3;
   localparam int unsigned ST_IRQ   = 7;

   localparam logic [1:0] SOFT_RESET_CODE = 2'b11;
   localparam logic [1:0] TX_IE_CODE      = 2'b01;

   typedef struct packed {
      logic irq;
      logic cts;
      logic dcd;
      logic empty;
   } stx_flags_t;
endpackage

// File: rtl/stx_regs.sv
module stx_regs #(
   parameter int unsigned TX_WORD_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cs,
   input  logic                 rd_en,
   input  logic                 wr_en,
   input  logic                 reg_sel,
   input  logic [7:0]           wdata,
   input  logic                 load_take,
   input  logic                 tx_done,
   output logic                 soft_rst,
   output logic                 hold_full,
   output logic [TX_WORD_W-1:0] hold_data,
   output logic                 irq
);
   import stx_pkg::*;

   logic ctrl_wr, data_wr, data_rd, tx_ie;

   assign ctrl_wr  = cs && wr_en && !reg_sel;
   assign data_wr  = cs && wr_en && reg_sel;
   assign data_rd  = cs && rd_en && reg_sel;
   assign soft_rst = ctrl_wr && (wdata[1:0] == SOFT_RESET_CODE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_full <= 1'b0;
         hold_data <= '0;
         tx_ie     <= 1'b0;
         irq       <= 1'b0;
      end else begin
         if (soft_rst)       hold_full <= 1'b0;
         else if (data_wr)   hold_full <= 1'b1;
         else if (load_take) hold_full <= 1'b0;

         if (data_wr) hold_data <= wdata[TX_WORD_W-1:0];

         if (soft_rst)     tx_ie <= 1'b0;
         else if (ctrl_wr) tx_ie <= (wdata[6:5] == TX_IE_CODE);

         if (soft_rst || data_wr || data_rd)       irq <= 1'b0;
         else if (tx_done && !hold_full && tx_ie)  irq <= 1'b1;
      end
   end
endmodule

// File: rtl/stx_shifter.sv
module stx_shifter #(
   parameter int unsigned TX_WORD_W = 8,
   parameter int unsigned OVS       = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 soft_rst,
   input  logic                 hold_full,
   input  logic [TX_WORD_W-1:0] hold_data,
   output logic                 load_take,
   output logic                 tx_done,
   output logic                 txd
);
   localparam int unsigned FRAME_BITS = TX_WORD_W + 2;
   localparam int unsigned BIT_CW     = $clog2(FRAME_BITS);
   localparam int unsigned TICK_CW    = (OVS > 1) ? $clog2(OVS) : 1;

   logic                  busy;
   logic                  bit_end;
   logic [BIT_CW-1:0]     bit_cnt;
   logic [FRAME_BITS-1:0] sreg;

   generate
      if (OVS > 1) begin : g_ovs
         logic [TICK_CW-1:0] tick_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               tick_cnt <= '0;
            else if (soft_rst || load_take)
               tick_cnt <= '0;
            else if (busy && tick)
               tick_cnt <= (tick_cnt == TICK_CW'(OVS - 1)) ? '0 : tick_cnt + 1'b1;
         end
         assign bit_end = tick && (tick_cnt == TICK_CW'(OVS - 1));
      end else begin : g_single
         assign bit_end = tick;
      end
   endgenerate

   assign tx_done   = busy && bit_end && (bit_cnt == BIT_CW'(FRAME_BITS - 1));
   assign load_take = hold_full && (!busy || tx_done) && !soft_rst;
   assign txd       = busy ? sreg[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         bit_cnt <= '0;
         sreg    <= '1;
      end else if (soft_rst) begin
         busy    <= 1'b0;
         bit_cnt <= '0;
         sreg    <= '1;
      end else if (load_take) begin
         busy    <= 1'b1;
         bit_cnt <= '0;
         sreg    <= {1'b1, hold_data, 1'b0};
      end else if (tx_done) begin
         busy    <= 1'b0;
         bit_cnt <= '0;
         sreg    <= '1;
      end else if (busy && bit_end) begin
         bit_cnt <= bit_cnt + 1'b1;
         sreg    <= {1'b1, sreg[FRAME_BITS-1:1]};
      end
   end
endmodule

// File: rtl/stx_status.sv
module stx_status (
   input  logic                 reg_sel,
   input  stx_pkg::stx_flags_t  flags,
   output logic [7:0]           rdata
);
   import stx_pkg::*;

   logic [7:0] status;

   always_comb begin
      status           = 8'h00;
      status[ST_EMPTY] = flags.empty;
      status[ST_DCD]   = flags.dcd;
      status[ST_CTS]   = flags.cts;
      status[ST_IRQ]   = flags.irq;
      rdata            = reg_sel ? 8'h00 : status;
   end
endmodule

// File: rtl/serial_tx_port.sv
module serial_tx_port #(
   parameter int unsigned TX_WORD_W = 8,
   parameter int unsigned OVS       = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_sel,
   input  logic       cs,
   input  logic       rd_en,
   input  logic       wr_en,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   input  logic       carrier_in,
   input  logic       cts_in,
   input  logic       bit_tick,
   output logic       txd,
   output logic       irq
);
   import stx_pkg::*;

   generate
      if (TX_WORD_W < 5 || TX_WORD_W > 8) begin : g_bad_word
         $error("serial_tx_port: TX_WORD_W must lie in 5..8");
      end
      if (OVS < 1) begin : g_bad_ovs
         $error("serial_tx_port: OVS must be at least 1");
      end
   endgenerate

   logic                 soft_rst;
   logic                 hold_full;
   logic [TX_WORD_W-1:0] hold_data;
   logic                 load_take;
   logic                 tx_done;
   stx_flags_t           flags;

   stx_regs #(.TX_WORD_W(TX_WORD_W)) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs        (cs),
      .rd_en     (rd_en),
      .wr_en     (wr_en),
      .reg_sel   (reg_sel),
      .wdata     (wdata),
      .load_take (load_take),
      .tx_done   (tx_done),
      .soft_rst  (soft_rst),
      .hold_full (hold_full),
      .hold_data (hold_data),
      .irq       (irq)
   );

   stx_shifter #(.TX_WORD_W(TX_WORD_W), .OVS(OVS)) i_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (bit_tick),
      .soft_rst  (soft_rst),
      .hold_full (hold_full),
      .hold_data (hold_data),
      .load_take (load_take),
      .tx_done   (tx_done),
      .txd       (txd)
   );

   assign flags.irq   = irq;
   assign flags.cts   = cts_in;
   assign flags.dcd   = carrier_in;
   assign flags.empty = !hold_full;

   stx_status i_status (
      .reg_sel (reg_sel),
      .flags   (flags),
      .rdata   (rdata)
   );
endmodule

// File: rtl/stx_chk.sv
module stx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       reg_sel,
   input logic       cs,
   input logic       rd_en,
   input logic       wr_en,
   input logic [7:0] wdata,
   input logic [7:0] rdata,
   input logic       txd,
   input logic       irq,
   input logic       hold_full,
   input logic       busy
);
   // R4
   irq_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_sel |-> (rdata[7] == irq));

   // R2
   empty_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_sel |-> (rdata[1] == !hold_full));

   // R6
   data_wr_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && wr_en && reg_sel) |=> hold_full);

   // R9
   data_wr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && wr_en && reg_sel) |=> !irq);

   // R9
   data_rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && rd_en && reg_sel) |=> !irq);

   // R10
   soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && wr_en && !reg_sel && wdata[1:0] == 2'b11) |=> (txd && !irq && !hold_full));

   // R5
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);

   // R5
   start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !txd);

   // R7
   irq_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $fell(busy));
endmodule

bind serial_tx_port stx_chk i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_sel   (reg_sel),
   .cs        (cs),
   .rd_en     (rd_en),
   .wr_en     (wr_en),
   .wdata     (wdata),
   .rdata     (rdata),
   .txd       (txd),
   .irq       (irq),
   .hold_full (hold_full),
   .busy      (i_shift.busy)
);

// File: tb/test_serial_tx_port.sv
`timescale 1ns/1ps
module test_serial_tx_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_sel = 1'b0, cs = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       carrier_in = 1'b0, cts_in = 1'b0, bit_tick = 1'b1;
   logic       txd, irq;

   int tests = 0;
   int fails = 0;
   bit done_flag = 1'b0;

   always #2 clk = ~clk;

   serial_tx_port i_serial_tx_port (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .cs(cs), .rd_en(rd_en),
      .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .carrier_in(carrier_in),
      .cts_in(cts_in), .bit_tick(bit_tick), .txd(txd), .irq(irq)
   );

   function automatic logic exp_bit(input logic [7:0] b, input int k);
      if (k == 0) return 1'b0;
      if (k == 9) return 1'b1;
      return b[k-1];
   endfunction

   function automatic logic [7:0] exp_status(input logic ir, input logic ct,
                                             input logic dc, input logic em);
      return {ir, 3'b000, ct, dc, em, 1'b0};
   endfunction

   task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string req);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %02h expected %02h at %0t", req, got, exp, $time);
      end
   endtask

   task automatic bus_wr(input logic s, input logic [7:0] v);
      @(negedge clk);
      cs = 1'b1; wr_en = 1'b1; reg_sel = s; wdata = v;
      @(negedge clk);
      cs = 1'b0; wr_en = 1'b0; reg_sel = 1'b0;
      #1;
   endtask

   task automatic bus_rd(input logic s, output logic [7:0] v);
      @(negedge clk);
      cs = 1'b1; rd_en = 1'b1; reg_sel = s;
      #1 v = rdata;
      @(negedge clk);
      cs = 1'b0; rd_en = 1'b0; reg_sel = 1'b0;
      #1;
   endtask

   task automatic peek_status(output logic [7:0] v);
      reg_sel = 1'b0;
      #1 v = rdata;
   endtask

   // Entered at the negedge right after the load edge; returns at the
   // negedge right after the edge that ends the stop bit.
   task automatic frame_check(input logic [7:0] b, input bit inject, input logic [7:0] nb);
      logic [7:0] st;
      for (int j = 1; j <= 160; j++) begin
         @(negedge clk);
         if (inject && j == 40) begin
            cs = 1'b1; wr_en = 1'b1; reg_sel = 1'b1; wdata = nb;
         end
         if (inject && j == 41) begin
            cs = 1'b0; wr_en = 1'b0;
            peek_status(st);
            chk({7'd0, st[1]}, 8'd0, "R2 pending byte clears empty flag");
         end
         if (j % 16 == 8) begin
            #1 chk({7'd0, txd}, {7'd0, exp_bit(b, j / 16)}, "R5 frame bit");
         end
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         fails++;
         $display("FAIL R5 watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] st, v, b, c;
      logic       ie;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state, R1 data register reads zero
      peek_status(st);
      chk(st, 8'h02, "R11 reset status");
      chk({7'd0, txd}, 8'd1, "R11 idle txd");
      chk({7'd0, irq}, 8'd0, "R11 irq low");
      reg_sel = 1'b1; #1;
      chk(rdata, 8'h00, "R1 data register reads 0");

      // R3 input levels, random patterns
      for (int i = 0; i < 6; i++) begin
         carrier_in = $urandom_range(0, 1);
         cts_in     = $urandom_range(0, 1);
         peek_status(st);
         chk(st, exp_status(1'b0, cts_in, carrier_in, 1'b1), "R3 carrier/cts in status");
      end
      carrier_in = 1'b0; cts_in = 1'b0;

      // R6, R5, R7, R4 single character with interrupts on
      bus_wr(1'b0, 8'h20);
      b = 8'hA5;
      bus_wr(1'b1, b);
      peek_status(st);
      chk({7'd0, st[1]}, 8'd0, "R2 held after write");
      @(negedge clk);
      peek_status(st);
      chk({7'd0, st[1]}, 8'd1, "R6 empty after load");
      chk({7'd0, txd}, 8'd0, "R6 start bit one cycle after write");
      frame_check(b, 1'b0, 8'h00);
      peek_status(st);
      chk({7'd0, irq}, 8'd1, "R7 irq at end of character");
      chk({7'd0, st[7]}, 8'd1, "R4 status bit 7 follows irq");

      // R9 data read clears
      bus_rd(1'b1, v);
      chk(v, 8'h00, "R1 data read value");
      chk({7'd0, irq}, 8'd0, "R9 data read clears irq");

      // R6 back to back, R8 no irq with pending byte
      b = 8'h3C; c = 8'hC1;
      bus_wr(1'b1, b);
      @(negedge clk);
      frame_check(b, 1'b1, c);
      chk({7'd0, irq}, 8'd0, "R8 no irq while byte pending");
      chk({7'd0, txd}, 8'd0, "R6 next start bit without gap");
      frame_check(c, 1'b0, 8'h00);
      chk({7'd0, irq}, 8'd1, "R7 irq after second character");

      // R9 data write clears
      b = 8'h0F;
      bus_wr(1'b1, b);
      chk({7'd0, irq}, 8'd0, "R9 data write clears irq");
      @(negedge clk);
      frame_check(b, 1'b0, 8'h00);
      chk({7'd0, irq}, 8'd1, "R7 irq after write-cleared character");

      // R10 soft reset clears irq and disables interrupts
      bus_wr(1'b0, 8'h23);
      peek_status(st);
      chk(st, 8'h02, "R10 soft reset status");
      chk({7'd0, irq}, 8'd0, "R10 soft reset clears irq");

      // R12 hold without ticks, then R10 abort mid character
      bit_tick = 1'b0;
      bus_wr(1'b1, 8'h55);
      @(negedge clk);
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (i % 8 == 0) chk({7'd0, txd}, 8'd0, "R12 start bit held without tick");
      end
      bit_tick = 1'b1;
      repeat (20) @(negedge clk);
      chk({7'd0, txd}, 8'd1, "R5 first data bit of 0x55");
      bus_wr(1'b0, 8'h03);
      chk({7'd0, txd}, 8'd1, "R10 txd idle after abort");
      peek_status(st);
      chk(st, 8'h02, "R10 holding empty after abort");
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (i % 10 == 9) chk({7'd0, txd}, 8'd1, "R10 txd stays idle");
      end

      // R10 interrupts stay disabled after soft reset
      b = 8'h81;
      bus_wr(1'b1, b);
      @(negedge clk);
      frame_check(b, 1'b0, 8'h00);
      chk({7'd0, irq}, 8'd0, "R10 interrupts disabled after soft reset");

      // R8 other enable codes
      bus_wr(1'b0, 8'h60);
      b = 8'hFE;
      bus_wr(1'b1, b);
      @(negedge clk);
      frame_check(b, 1'b0, 8'h00);
      chk({7'd0, irq}, 8'd0, "R8 code 11 in bits 6:5 disables irq");

      // Random control/data mix
      for (int i = 0; i < 24; i++) begin
         v = 8'($urandom);
         if (v[1:0] == 2'b11) v[0] = 1'b0;
         ie = (v[6:5] == 2'b01);
         bus_wr(1'b0, v);
         b = 8'($urandom);
         bus_wr(1'b1, b);
         chk({7'd0, irq}, 8'd0, "R9 write clears irq (random)");
         @(negedge clk);
         frame_check(b, 1'b0, 8'h00);
         peek_status(st);
         chk({7'd0, irq}, {7'd0, ie}, "R7 irq vs enable code (random)");
         chk(st, exp_status(ie, 1'b0, 1'b0, 1'b1), "R1 status after character (random)");
      end

      done_flag = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule